// File: doc/BRIEF.md
# Strobed Per-Core Local Reset and NMI Controller

This block holds the local-reset state of each core in a multicore device and issues non-maskable interrupts to it. A core-select bus with one bit per core and two active-low command pins, local reset and NMI, arrive asynchronously. They are synchronized and decoded into one of four commands: hold in reset, free from reset, NMI, or none. Nothing acts on the level of these pins.

A separate active-low strobe qualifies the command. The strobe has to make a complete high-low-high pulse. Its low phase must last a minimum number of clocks. The decoded command must be steady for a setup window before the strobe falls, and it must stay unchanged until the strobe has risen again. The command latched at the synchronized falling edge is executed at the synchronized rising edge. A strobe that is too short is dropped and sets a sticky error flag. A command that moves during the pulse is dropped silently.

There is no data stream here, so the ports are plain control and status pins with no valid/ready handshake. A global active-low reset puts every core into local reset and clears the error flag and any pending pulse.

Top module: `core_rstnmi_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it, `core_rst_o` is all ones, `core_nmi_o` is all zeros and `short_err_o` is 0.
- R2: With `lrst_n_i`=0 and `nmi_n_i`=1 during a qualified strobe, every core whose `sel_i` bit is 1 enters local reset (`core_rst_o` bit = 1), and all other cores keep their state.
- R3: With `lrst_n_i`=1 and `nmi_n_i`=1 during a qualified strobe, every selected core leaves local reset (`core_rst_o` bit = 0), and all other cores keep their state.
- R4: With `lrst_n_i`=1 and `nmi_n_i`=0 during a qualified strobe, every selected core that is out of reset gets exactly one single-clock pulse on its `core_nmi_o` bit. A core held in reset gets none, and reset state does not change.
- R5: A command acts only after `stb_n_i` rises again after a fall that followed a high level. A strobe that is held low, or that was already low when `rst_n` was released, changes nothing. The state changes within 8 clocks of the rising edge.
- R6: If `sel_i`, `lrst_n_i` or `nmi_n_i` changes the decoded command while the strobe is low, the command is discarded with no state change and no error.
- R7: A command that changed fewer than SETUP_CYC synchronized clocks before the strobe fell is discarded. This includes a change in the same clock as the fall.
- R8: A strobe low time shorter than MIN_LOW clocks (default 4) is ignored and sets `short_err_o`, which stays 1 until `rst_n` goes low. A low time of exactly MIN_LOW clocks is accepted.
- R9: A qualified strobe with `sel_i` = 0 has no effect.
- R10: A qualified strobe with `lrst_n_i`=0 and `nmi_n_i`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Global active-low reset |
| sel_i | input | NCORE | Asynchronous core-select, bit i selects core i |
| lrst_n_i | input | 1 | Asynchronous active-low local-reset command |
| nmi_n_i | input | 1 | Asynchronous active-low NMI command |
| stb_n_i | input | 1 | Asynchronous active-low enable strobe |
| core_rst_o | output | NCORE | Per-core local reset state, 1 = held |
| core_nmi_o | output | NCORE | Per-core single-clock NMI pulse |
| short_err_o | output | 1 | Sticky flag for a too-short strobe |

## Verification
The hardest cases to reach are the discard paths, because the command pins pass through synchronizers and the bench cannot see the synchronized strobe edge directly. The bench drives every pin on the falling clock edge, so all bits cross the synchronizers together. This lets it place a command change in the exact clock of the strobe fall (R7) or in the middle of the low phase (R6). It also runs a low time of exactly MIN_LOW and one of MIN_LOW-1 to hit both sides of the short-pulse boundary. A strobe that is already low when reset is released checks that the block does not treat reset as the high phase of the pulse.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_HOLD = 2'd1,
    CMD_FREE = 2'd2,
    CMD_NMI  = 2'd3
  } rn_cmd_e;

  // Pin-level decode: both low is not a legal request
  function automatic rn_cmd_e rn_decode(input logic lrst_n, input logic nmi_n);
    rn_cmd_e c;
    case ({lrst_n, nmi_n})
      2'b01:   c = CMD_HOLD;
      2'b11:   c = CMD_FREE;
      2'b10:   c = CMD_NMI;
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rn_sync.sv
module rn_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rn_strobe_qual.sv
module rn_strobe_qual
  import rn_pkg::*;
#(
  parameter int NCORE     = 4,
  parameter int MIN_LOW   = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_stb_n,
  input  logic [NCORE-1:0] s_sel,
  input  logic             s_lrst_n,
  input  logic             s_nmi_n,
  output logic             exec_vld_o,
  output rn_cmd_e          exec_cmd_o,
  output logic [NCORE-1:0] exec_sel_o,
  output logic             short_err_o
);
  localparam int CW = NCORE + 2;
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int SW = $clog2(SETUP_CYC + 1) < 1 ? 1 : $clog2(SETUP_CYC + 1);

  logic [CW-1:0] cmd_vec, cmd_prev_q, held_q;
  logic          stb_q, armed_q, ok_q, exec_vld_q, err_q;
  logic [LW-1:0] low_cnt_q;
  logic [SW-1:0] steady_q;
  rn_cmd_e       exec_cmd_q;
  logic [NCORE-1:0] exec_sel_q;
  logic fall, rise, chg, setup_ok, held_chg, long_ok;

  assign cmd_vec  = {s_sel, logic'(rn_decode(s_lrst_n, s_nmi_n) >> 1), logic'(rn_decode(s_lrst_n, s_nmi_n) & 2'b01)};
  assign fall     = stb_q & ~s_stb_n;
  assign rise     = ~stb_q & s_stb_n;
  assign chg      = cmd_vec != cmd_prev_q;
  assign setup_ok = !chg && (steady_q >= SW'(SETUP_CYC));
  assign held_chg = cmd_vec != held_q;
  assign long_ok  = low_cnt_q >= LW'(MIN_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      cmd_prev_q <= '0;
      held_q     <= '0;
      steady_q   <= '0;
      armed_q    <= 1'b0;
      ok_q       <= 1'b0;
      low_cnt_q  <= '0;
      exec_vld_q <= 1'b0;
      exec_cmd_q <= CMD_NONE;
      exec_sel_q <= '0;
      err_q      <= 1'b0;
    end else begin
      stb_q      <= s_stb_n;
      cmd_prev_q <= cmd_vec;
      exec_vld_q <= 1'b0;
      if (chg)                           steady_q <= '0;
      else if (steady_q < SW'(SETUP_CYC)) steady_q <= steady_q + 1'b1;

      if (fall) begin
        armed_q   <= 1'b1;
        held_q    <= cmd_vec;
        ok_q      <= setup_ok;
        low_cnt_q <= LW'(1);
      end else if (armed_q && !s_stb_n) begin
        if (held_chg) ok_q <= 1'b0;
        if (!long_ok) low_cnt_q <= low_cnt_q + 1'b1;
      end else if (armed_q && rise) begin
        armed_q <= 1'b0;
        if (!long_ok) begin
          err_q <= 1'b1;
        end else if (ok_q && !held_chg) begin
          exec_vld_q <= 1'b1;
          exec_cmd_q <= rn_cmd_e'(held_q[1:0]);
          exec_sel_q <= held_q[CW-1:2];
        end
      end
    end
  end

  assign exec_vld_o  = exec_vld_q;
  assign exec_cmd_o  = exec_cmd_q;
  assign exec_sel_o  = exec_sel_q;
  assign short_err_o = err_q;

  // R8: a too-short low phase never executes and always flags
  p_short_no_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rise && !long_ok) |=> (!exec_vld_q && err_q));
  // R8: flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R6: command moved at or before the rise means discard
  p_hold_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rise && held_chg) |=> !exec_vld_q);
  // R5: execution only follows a synchronized rising edge
  p_exec_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_vld_q |-> ($past(s_stb_n) && !$past(stb_q)));
endmodule

// File: rtl/rn_core_bank.sv
module rn_core_bank
  import rn_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_vld_i,
  input  rn_cmd_e          exec_cmd_i,
  input  logic [NCORE-1:0] exec_sel_i,
  output logic [NCORE-1:0] core_rst_o,
  output logic [NCORE-1:0] core_nmi_o
);
  logic [NCORE-1:0] rst_q, nmi_q;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_q[i] <= 1'b1;
        nmi_q[i] <= 1'b0;
      end else begin
        nmi_q[i] <= 1'b0;
        if (exec_vld_i && exec_sel_i[i]) begin
          case (exec_cmd_i)
            CMD_HOLD: rst_q[i] <= 1'b1;
            CMD_FREE: rst_q[i] <= 1'b0;
            CMD_NMI:  nmi_q[i] <= !rst_q[i];
            default:  ;
          endcase
        end
      end
    end
  end

  assign core_rst_o = rst_q;
  assign core_nmi_o = nmi_q;

  // R4: no NMI reaches a core held in reset
  p_nmi_not_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q & rst_q) == '0);
  // R4: pulses last a single clock
  p_nmi_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_q) |=> (nmi_q == '0));
  // R2: reset state moves only on an executed command
  p_state_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_vld_i |=> $stable(rst_q));
  // R3: release clears every selected core
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_vld_i && exec_cmd_i == CMD_FREE) |=> ((rst_q & $past(exec_sel_i)) == '0));
  // R9: empty select touches nothing
  p_empty_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_vld_i && exec_sel_i == '0) |=> ($stable(rst_q) && nmi_q == '0));
endmodule

// File: rtl/core_rstnmi_ctrl.sv
module core_rstnmi_ctrl
  import rn_pkg::*;
#(
  parameter int NCORE       = 4,
  parameter int MIN_LOW     = 4,
  parameter int SETUP_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] sel_i,
  input  logic             lrst_n_i,
  input  logic             nmi_n_i,
  input  logic             stb_n_i,
  output logic [NCORE-1:0] core_rst_o,
  output logic [NCORE-1:0] core_nmi_o,
  output logic             short_err_o
);
  localparam int PW = NCORE + 3;

  logic [PW-1:0]    pins_s;
  logic             s_stb_n, s_lrst_n, s_nmi_n;
  logic [NCORE-1:0] s_sel;
  logic             exec_vld;
  rn_cmd_e          exec_cmd;
  logic [NCORE-1:0] exec_sel;

  rn_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({stb_n_i, sel_i, lrst_n_i, nmi_n_i}),
    .q_o   (pins_s)
  );

  assign {s_stb_n, s_sel, s_lrst_n, s_nmi_n} = pins_s;

  rn_strobe_qual #(.NCORE(NCORE), .MIN_LOW(MIN_LOW), .SETUP_CYC(SETUP_CYC)) i_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_stb_n     (s_stb_n),
    .s_sel       (s_sel),
    .s_lrst_n    (s_lrst_n),
    .s_nmi_n     (s_nmi_n),
    .exec_vld_o  (exec_vld),
    .exec_cmd_o  (exec_cmd),
    .exec_sel_o  (exec_sel),
    .short_err_o (short_err_o)
  );

  rn_core_bank #(.NCORE(NCORE)) i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_vld_i (exec_vld),
    .exec_cmd_i (exec_cmd),
    .exec_sel_i (exec_sel),
    .core_rst_o (core_rst_o),
    .core_nmi_o (core_nmi_o)
  );
endmodule

// File: tb/test_core_rstnmi_ctrl.sv
module test_core_rstnmi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel_i = '0;
  logic       lrst_n_i = 1'b1, nmi_n_i = 1'b1, stb_n_i = 1'b1;
  logic [3:0] core_rst_o, core_nmi_o;
  logic       short_err_o;

  int n_chk = 0, n_bad = 0;
  int nmi_cnt [4];
  bit done = 1'b0;

  always #10 clk = ~clk;

  core_rstnmi_ctrl i_core_rstnmi_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .lrst_n_i(lrst_n_i),
    .nmi_n_i(nmi_n_i), .stb_n_i(stb_n_i), .core_rst_o(core_rst_o),
    .core_nmi_o(core_nmi_o), .short_err_o(short_err_o)
  );

  initial for (int c = 0; c < 4; c++) nmi_cnt[c] = 0;
  always @(posedge clk)
    for (int c = 0; c < 4; c++) if (core_nmi_o[c]) nmi_cnt[c] = nmi_cnt[c] + 1;

  // {sel, lrst_n, nmi_n, low_clocks, exp_rst, exp_nmi}
  localparam logic [17:0] VEC [10] = '{
    {4'b0011, 1'b1, 1'b1, 4'd5, 4'b1100, 4'b0000},  // R3
    {4'b1111, 1'b1, 1'b0, 4'd5, 4'b1100, 4'b0011},  // R4
    {4'b0001, 1'b0, 1'b1, 4'd5, 4'b1101, 4'b0000},  // R2
    {4'b0000, 1'b1, 1'b1, 4'd5, 4'b1101, 4'b0000},  // R9
    {4'b1110, 1'b1, 1'b1, 4'd6, 4'b0001, 4'b0000},  // R3
    {4'b1111, 1'b1, 1'b0, 4'd5, 4'b0001, 4'b1110},  // R4
    {4'b1111, 1'b0, 1'b0, 4'd5, 4'b0001, 4'b0000},  // R10
    {4'b1010, 1'b0, 1'b1, 4'd7, 4'b1011, 4'b0000},  // R2
    {4'b0100, 1'b1, 1'b0, 4'd5, 4'b1011, 4'b0100},  // R4
    {4'b1111, 1'b1, 1'b1, 4'd4, 4'b0000, 4'b0000}   // R8 boundary
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int low);
    stb_n_i = 1'b0;
    cyc(low);
    stb_n_i = 1'b1;
    cyc(8);
  endtask

  task automatic set_cmd(input logic [3:0] s, input logic l, input logic n);
    sel_i = s; lrst_n_i = l; nmi_n_i = n;
    cyc(5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
  endtask

  function automatic logic [3:0] nmi_delta(input int base [4]);
    logic [3:0] m;
    for (int c = 0; c < 4; c++) m[c] = (nmi_cnt[c] - base[c]) == 1;
    return m;
  endfunction

  function automatic int nmi_total(input int base [4]);
    int t = 0;
    for (int c = 0; c < 4; c++) t += nmi_cnt[c] - base[c];
    return t;
  endfunction

  initial begin
    int base [4];
    cyc(2);
    check(core_rst_o == 4'hF && core_nmi_o == 0 && short_err_o == 0, "R1 during reset",
          {core_rst_o, core_nmi_o, 3'b0, short_err_o}, 32'hF00);
    do_reset();
    check(core_rst_o == 4'hF && short_err_o == 0, "R1 after reset", core_rst_o, 4'hF);

    for (int v = 0; v < 10; v++) begin
      set_cmd(VEC[v][17:14], VEC[v][13], VEC[v][12]);
      base = nmi_cnt;
      pulse(int'(VEC[v][11:8]));
      check(core_rst_o == VEC[v][7:4], $sformatf("R2/R3/R9/R10 vec%0d rst", v), core_rst_o, VEC[v][7:4]);
      check(nmi_delta(base) == VEC[v][3:0] && nmi_total(base) == $countones(VEC[v][3:0]),
            $sformatf("R4 vec%0d nmi", v), nmi_total(base), $countones(VEC[v][3:0]));
      check(short_err_o == 1'b0, $sformatf("R8 vec%0d no err", v), short_err_o, 0);
    end

    // R8: one clock short
    set_cmd(4'b1111, 1'b0, 1'b1);
    pulse(3);
    check(core_rst_o == 4'h0, "R8 short ignored", core_rst_o, 4'h0);
    check(short_err_o == 1'b1, "R8 flag set", short_err_o, 1);
    pulse(5);
    check(core_rst_o == 4'hF && short_err_o == 1'b1, "R8 sticky, later cmd works",
          {core_rst_o, short_err_o}, 5'h1F);
    do_reset();
    check(short_err_o == 1'b0 && core_rst_o == 4'hF, "R1 reset clears flag", short_err_o, 0);

    // R5: held low, no action until rise
    set_cmd(4'b0110, 1'b1, 1'b1);
    stb_n_i = 1'b0;
    cyc(20);
    check(core_rst_o == 4'hF, "R5 held low no action", core_rst_o, 4'hF);
    stb_n_i = 1'b1;
    cyc(8);
    check(core_rst_o == 4'b1001, "R5 acts on rise", core_rst_o, 4'b1001);

    // R6: select changes while low
    set_cmd(4'b1000, 1'b1, 1'b1);
    stb_n_i = 1'b0;
    cyc(3);
    sel_i = 4'b0001;
    cyc(3);
    stb_n_i = 1'b1;
    cyc(8);
    check(core_rst_o == 4'b1001 && short_err_o == 0, "R6 change during low discarded",
          {core_rst_o, short_err_o}, 5'b10010);

    // R7: command changes in the same clock as the fall
    set_cmd(4'b1000, 1'b0, 1'b0);
    sel_i = 4'b0001; lrst_n_i = 1'b1; nmi_n_i = 1'b1; stb_n_i = 1'b0;
    cyc(6);
    stb_n_i = 1'b1;
    cyc(8);
    check(core_rst_o == 4'b1001, "R7 no setup discarded", core_rst_o, 4'b1001);
    set_cmd(4'b0001, 1'b1, 1'b1);
    pulse(5);
    check(core_rst_o == 4'b1000, "R7 steady command accepted", core_rst_o, 4'b1000);

    // R5: strobe already low at reset release
    sel_i = 4'b1111; lrst_n_i = 1'b1; nmi_n_i = 1'b1; stb_n_i = 1'b0;
    do_reset();
    cyc(6);
    stb_n_i = 1'b1;
    cyc(8);
    check(core_rst_o == 4'hF, "R5 low from reset ignored", core_rst_o, 4'hF);

    // R4: NMI to cores in reset gives nothing
    set_cmd(4'b1111, 1'b1, 1'b0);
    base = nmi_cnt;
    pulse(5);
    check(nmi_total(base) == 0 && core_rst_o == 4'hF, "R4 no nmi in reset", nmi_total(base), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule